// File: doc/BRIEF.md
# Streaming Sample Capture Serial Master

The block sends snapshots of a bank of sixteen 24-bit signed samples to an external SPI-style slave device. A capture pulse copies the whole bank into internal storage in one clock. The block then sends a burst of 1 to 16 words from that copy as 32-bit sign-extended values, one word per select-low window. The block is always the master. It drives a select strobe, a data line and a serial clock that it derives from the system clock through a programmable divisor.

Transmission runs only while the enable input is high and the register-access SPI port is not in use. If either condition drops, the block returns to idle at once. The word count and the divisor are taken from the configuration inputs when a burst starts. Set them before raising enable so the outputs never show inconsistent levels. A capture that arrives during a burst is remembered, and a new burst starts from a fresh snapshot as soon as the current one ends.

Top module: `cap_stream_tx`

## Requirements
- R1: After reset, `hs_sel_n`, `hs_dat` and `hs_clk` are all 1 and stay 1 until a burst starts.
- R2: While `cfg_enable` is 0, a `capture` pulse starts no burst and is not remembered.
- R3: While `spi_port_busy` is 1, `cfg_enable` has no effect: a `capture` starts no burst and is not remembered for later.
- R4: A burst sends exactly `cfg_words_m1`+1 words. Word k carries slot k, and slot k sits in `samp_bus` bits [24k+23:24k].
- R5: Each word is the 24-bit slot value sign-extended to 32 bits (bit 23 copied into bits 31..24). It is sent most significant bit first, 32 bits per select-low window.
- R6: `hs_clk` idles at 1. Within a word, `hs_dat` changes only together with a falling edge of `hs_clk` and holds while `hs_clk` is 1. The slave samples on the rising edge.
- R7: Each half period of `hs_clk` lasts `cfg_div`+1 system clock cycles. One bit therefore takes 2*(`cfg_div`+1) cycles.
- R8: All slots are copied at the cycle a burst starts. Later changes on `samp_bus` do not alter the words of that burst.
- R9: A `capture` during a burst is held. When the burst ends, a new burst starts from a snapshot taken at that moment.
- R10: Between two words of a burst, `hs_sel_n` is 1 for exactly one serial clock period, 2*(`cfg_div`+1) cycles.
- R11: Clearing `cfg_enable` (or setting `spi_port_busy`) during a burst returns all three outputs to 1 after the next clock edge and discards any held capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Enable bit for the capture port |
| spi_port_busy | input | 1 | 1 while the register-access SPI port is the active host interface |
| cfg_words_m1 | input | 4 | Words per burst minus one |
| cfg_div | input | 4 | Serial clock half period minus one, in system clocks |
| samp_bus | input | 384 | Sixteen 24-bit signed samples, slot k at bits [24k+23:24k] |
| capture | input | 1 | Snapshot and send request, one-cycle pulse |
| hs_sel_n | output | 1 | Select strobe, low while a word is shifted |
| hs_dat | output | 1 | Serial data, MSB first |
| hs_clk | output | 1 | Generated serial clock |

## Verification
A wrong phase or word counter appears at the ports within one word time. Such a fault shows up as a select window that holds a bit count other than 32, a select-high gap of the wrong length, or an extra or missing window at the end of a burst. A snapshot that reloads or misses a load corrupts the reassembled words of the burst where it happens. A fault in the hold or abort logic shows up as a burst that appears or fails to appear within one burst time of the stimulus. The bench rebuilds every word from the pins and checks each bit period and gap length, so a divisor error is seen on the first bit.

// File: rtl/cst_pkg.sv
package cst_pkg;
  // Word format on the wire is fixed by the protocol.
  localparam int unsigned SAMP_W   = 24;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BIT_W    = $clog2(WORD_W);
  // Phases per word: two per bit plus two idle phases of select high.
  localparam int unsigned PHASES   = 2 * WORD_W + 2;
  localparam int unsigned PH_W     = $clog2(PHASES);

  function automatic logic [WORD_W-1:0] sign_extend(input logic [SAMP_W-1:0] s);
    return {{(WORD_W - SAMP_W){s[SAMP_W-1]}}, s};
  endfunction

  function automatic logic msb_first_bit(input logic [WORD_W-1:0] w,
                                         input logic [BIT_W-1:0]  n);
    return w[BIT_W'(WORD_W - 1) - n];
  endfunction
endpackage

// File: rtl/cst_tick_gen.sv
module cst_tick_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!busy || restart)  cnt_q <= '0;
    else if (cnt_q == div_q)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick = busy && (cnt_q == div_q);
endmodule

// File: rtl/cst_snapshot.sv
module cst_snapshot
  import cst_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [SLOTS*SAMP_W-1:0] samp_bus,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORD_W-1:0]       rd_word,
  output logic [SLOTS*SAMP_W-1:0] snap_flat
);
  logic [SAMP_W-1:0] snap_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap_q[g] <= '0;
      else if (load) snap_q[g] <= samp_bus[g*SAMP_W +: SAMP_W];
    end
    assign snap_flat[g*SAMP_W +: SAMP_W] = snap_q[g];
  end

  assign rd_word = sign_extend(snap_q[rd_idx]);
endmodule

// File: rtl/cst_seq.sv
module cst_seq
  import cst_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned DIV_W = 4,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             capture,
  input  logic [IDX_W-1:0] cfg_words_m1,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tick,
  output logic             busy,
  output logic             start,
  output logic             burst_end,
  output logic             pend,
  output logic [PH_W-1:0]  phase,
  output logic [IDX_W-1:0] word_idx,
  output logic [IDX_W-1:0] last_q,
  output logic [DIV_W-1:0] div_q
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic phase_end;

  assign phase_end = tick && (phase == LAST_PH);
  assign burst_end = phase_end && (word_idx == last_q);
  assign start     = run_en && (capture || pend) && (!busy || burst_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      phase    <= '0;
      word_idx <= '0;
      last_q   <= '0;
      div_q    <= '0;
    end else if (!run_en) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      phase    <= '0;
      word_idx <= '0;
    end else begin
      pend <= busy && !start && (pend || capture);
      if (start) begin
        busy     <= 1'b1;
        phase    <= '0;
        word_idx <= '0;
        last_q   <= cfg_words_m1;
        div_q    <= cfg_div;
      end else if (burst_end) begin
        busy     <= 1'b0;
        phase    <= '0;
      end else if (phase_end) begin
        phase    <= '0;
        word_idx <= word_idx + 1'b1;
      end else if (tick) begin
        phase    <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cap_stream_tx.sv
module cap_stream_tx
  import cst_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned DIV_W = 4,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_enable,
  input  logic                    spi_port_busy,
  input  logic [IDX_W-1:0]        cfg_words_m1,
  input  logic [DIV_W-1:0]        cfg_div,
  input  logic [SLOTS*SAMP_W-1:0] samp_bus,
  input  logic                    capture,
  output logic                    hs_sel_n,
  output logic                    hs_dat,
  output logic                    hs_clk
);
  logic                    run_en;
  logic                    busy, start, burst_end, pend, tick, in_word;
  logic [PH_W-1:0]         phase;
  logic [IDX_W-1:0]        word_idx, last_q;
  logic [DIV_W-1:0]        div_q;
  logic [WORD_W-1:0]       cur_word;
  logic [SLOTS*SAMP_W-1:0] snap_flat;

  // The register-access port takes precedence over the enable bit.
  assign run_en = cfg_enable && !spi_port_busy;

  cst_seq #(.SLOTS(SLOTS), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .capture(capture),
    .cfg_words_m1(cfg_words_m1), .cfg_div(cfg_div), .tick(tick),
    .busy(busy), .start(start), .burst_end(burst_end), .pend(pend),
    .phase(phase), .word_idx(word_idx), .last_q(last_q), .div_q(div_q)
  );

  cst_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .busy(busy), .restart(start),
    .div_q(div_q), .tick(tick)
  );

  cst_snapshot #(.SLOTS(SLOTS)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(start), .samp_bus(samp_bus),
    .rd_idx(word_idx), .rd_word(cur_word), .snap_flat(snap_flat)
  );

  // Even phase: clock low with a new bit; odd phase: clock high, bit held.
  assign in_word  = busy && (phase < PH_W'(2 * WORD_W));
  assign hs_sel_n = !in_word;
  assign hs_clk   = !(in_word && !phase[0]);
  assign hs_dat   = in_word ? msb_first_bit(cur_word, phase[BIT_W:1]) : 1'b1;
endmodule

// File: rtl/cst_chk.sv
module cst_chk #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned SNAP_W = 384,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              capture,
  input logic              busy,
  input logic              start,
  input logic              pend,
  input logic [IDX_W-1:0]  word_idx,
  input logic [IDX_W-1:0]  last_q,
  input logic [SNAP_W-1:0] snap_flat,
  input logic              hs_sel_n,
  input logic              hs_dat,
  input logic              hs_clk
);
  // R11
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (hs_sel_n && hs_clk && hs_dat));

  // R6
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sel_n |-> hs_clk);

  // R6
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_sel_n && hs_clk && !$past(hs_sel_n) && $past(hs_clk))
      |-> (hs_dat == $past(hs_dat)));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(snap_flat));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && busy && run_en && !start) |=> pend);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (word_idx <= last_q));
endmodule

bind cap_stream_tx cst_chk #(.SLOTS(SLOTS), .SNAP_W(SLOTS*cst_pkg::SAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .capture(capture),
  .busy(busy), .start(start), .pend(pend), .word_idx(word_idx),
  .last_q(last_q), .snap_flat(snap_flat),
  .hs_sel_n(hs_sel_n), .hs_dat(hs_dat), .hs_clk(hs_clk)
);

// File: tb/sim_cap_stream_tx.sv
module sim_cap_stream_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_enable = 1'b0, spi_port_busy = 1'b0, capture = 1'b0;
  logic [3:0]   cfg_words_m1 = '0, cfg_div = '0;
  logic [383:0] samp_bus = '0;
  logic         hs_sel_n, hs_dat, hs_clk;

  int n_checks = 0, n_errors = 0;

  always #5 clk = ~clk;

  cap_stream_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .spi_port_busy(spi_port_busy), .cfg_words_m1(cfg_words_m1),
    .cfg_div(cfg_div), .samp_bus(samp_bus), .capture(capture),
    .hs_sel_n(hs_sel_n), .hs_dat(hs_dat), .hs_clk(hs_clk)
  );

  // Pin monitor: rebuilds words from the rising edges of the serial clock.
  logic [31:0] rx_word [64];
  int          rx_bits [64];
  int          rx_n = 0, sel_falls = 0;
  int          min_gap = 1 << 30, max_gap = 0, min_per = 1 << 30, max_per = 0;
  logic [31:0] shreg = '0;
  int          bitcnt = 0, gap_cnt = 0, cyc = 0, last_rise = 0;
  logic        prev_clk = 1'b1, prev_sel = 1'b1, have_rise = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (!hs_sel_n && !prev_clk && hs_clk) begin
        shreg  = {shreg[30:0], hs_dat};
        bitcnt = bitcnt + 1;
        if (have_rise) begin
          if (cyc - last_rise < min_per) min_per = cyc - last_rise;
          if (cyc - last_rise > max_per) max_per = cyc - last_rise;
        end
        have_rise = 1'b1;
        last_rise = cyc;
      end
      if (prev_sel && !hs_sel_n) begin
        sel_falls = sel_falls + 1;
        if (rx_n > 0) begin
          if (gap_cnt < min_gap) min_gap = gap_cnt;
          if (gap_cnt > max_gap) max_gap = gap_cnt;
        end
        have_rise = 1'b0;
      end
      if (!prev_sel && hs_sel_n && rx_n < 64) begin
        rx_word[rx_n] = shreg;
        rx_bits[rx_n] = bitcnt;
        rx_n   = rx_n + 1;
        bitcnt = 0;
        gap_cnt = 0;
      end
      if (hs_sel_n) gap_cnt = gap_cnt + 1;
    end
    prev_clk = hs_clk;
    prev_sel = hs_sel_n;
  end

  task automatic clear_mon();
    rx_n = 0; sel_falls = 0; bitcnt = 0; gap_cnt = 0;
    min_gap = 1 << 30; max_gap = 0; min_per = 1 << 30; max_per = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] samp_val(input int seed, input int i);
    logic [31:0] v;
    if (i == (seed % 16)) return 24'h800000;
    if (i == ((seed + 5) % 16)) return 24'h7FFFFF;
    v = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h00ABCDEF + 32'h1234;
    return v[23:0];
  endfunction

  function automatic logic [31:0] exp_word(input int seed, input int i);
    logic [23:0] s;
    s = samp_val(seed, i);
    return {{8{s[23]}}, s};
  endfunction

  task automatic load_samples(input int seed);
    @(negedge clk);
    for (int i = 0; i < 16; i++) samp_bus[i*24 +: 24] = samp_val(seed, i);
  endtask

  task automatic pulse_capture();
    @(negedge clk) capture = 1'b1;
    @(negedge clk) capture = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (rx_n >= n && hs_sel_n) break;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic run_burst(input int wm1, input int div, input int seed);
    cfg_words_m1 = 4'(wm1);
    cfg_div      = 4'(div);
    load_samples(seed);
    clear_mon();
    pulse_capture();
    wait_words(wm1 + 1);
    repeat (140 * (div + 1)) @(negedge clk);
    chk("R4 word count", 32'(rx_n), 32'(wm1 + 1));
    for (int i = 0; i <= wm1; i++) begin
      chk("R5 bits per window", 32'(rx_bits[i]), 32);
      chk("R5 sign-extended word", rx_word[i], exp_word(seed, i));
    end
    chk("R7 min bit period", 32'(min_per), 32'(2 * (div + 1)));
    chk("R7 max bit period", 32'(max_per), 32'(2 * (div + 1)));
    if (wm1 > 0) begin
      chk("R10 min word gap", 32'(min_gap), 32'(2 * (div + 1)));
      chk("R10 max word gap", 32'(max_gap), 32'(2 * (div + 1)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle levels while reset is held
    chk("R1 sel in reset", 32'(hs_sel_n), 1);
    chk("R1 dat in reset", 32'(hs_dat), 1);
    chk("R1 clk in reset", 32'(hs_clk), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", {29'b0, hs_sel_n, hs_dat, hs_clk}, 32'h7);

    // R2: capture while disabled is dropped
    cfg_words_m1 = 4'd3; cfg_div = 4'd0;
    load_samples(1);
    clear_mon();
    pulse_capture();
    repeat (400) @(negedge clk);
    chk("R2 no burst when disabled", 32'(sel_falls), 0);
    cfg_enable = 1'b1;
    repeat (400) @(negedge clk);
    chk("R2 capture not held", 32'(sel_falls), 0);

    // R3: enable has no effect while the SPI port is in use
    spi_port_busy = 1'b1;
    pulse_capture();
    repeat (400) @(negedge clk);
    chk("R3 no burst with SPI busy", 32'(sel_falls), 0);
    spi_port_busy = 1'b0;
    repeat (400) @(negedge clk);
    chk("R3 capture not held", 32'(sel_falls), 0);

    // R4 R5 R7 R10: sweep every word count over four divisors
    for (int w = 0; w < 16; w++) run_burst(w, w % 4, w + 3);
    run_burst(15, 5, 40);

    // R8: bank changes during the burst do not reach the words
    cfg_words_m1 = 4'd3; cfg_div = 4'd0;
    load_samples(50);
    clear_mon();
    pulse_capture();
    repeat (30) @(negedge clk);
    load_samples(51);
    wait_words(4);
    chk("R8 word count", 32'(rx_n), 4);
    for (int i = 0; i < 4; i++) chk("R8 snapshot word", rx_word[i], exp_word(50, i));

    // R9: a capture during a burst is held and starts a second burst
    cfg_words_m1 = 4'd1; cfg_div = 4'd1;
    load_samples(60);
    clear_mon();
    pulse_capture();
    repeat (50) @(negedge clk);
    load_samples(61);
    pulse_capture();
    wait_words(4);
    repeat (300) @(negedge clk);
    chk("R9 total words", 32'(rx_n), 4);
    for (int i = 0; i < 2; i++) begin
      chk("R9 first burst", rx_word[i], exp_word(60, i));
      chk("R9 second burst", rx_word[i + 2], exp_word(61, i));
    end

    // R11: clearing enable mid-burst idles the pins and drops the held capture
    cfg_words_m1 = 4'd15; cfg_div = 4'd0;
    load_samples(70);
    clear_mon();
    pulse_capture();
    repeat (100) @(negedge clk);
    pulse_capture();
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R11 idle after disable", {29'b0, hs_sel_n, hs_dat, hs_clk}, 32'h7);
    cfg_enable = 1'b1;
    clear_mon();
    repeat (500) @(negedge clk);
    chk("R11 held capture dropped", 32'(sel_falls), 0);

    // R11: the SPI port taking over also aborts
    clear_mon();
    pulse_capture();
    repeat (80) @(negedge clk);
    spi_port_busy = 1'b1;
    @(negedge clk);
    chk("R11 idle after SPI takeover", {29'b0, hs_sel_n, hs_dat, hs_clk}, 32'h7);
    spi_port_busy = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule